// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous requester and an asynchronous static RAM that has a 20-bit word address and a 4-bit data bus. The requester presents one word access at a time: a strobe, a write flag, an address and write data. The controller converts each access into a timed sequence on the RAM's active-low select, output-enable and write-enable pins. It returns read data with a one-cycle valid pulse and holds `busy` high until the RAM side has fully recovered.

All pin timing is set in nanoseconds through parameters. Each phase length is the timing value divided by the clock period, rounded up, and never less than one cycle. The data bus is split into an output word, an input word and a drive enable, so that the surrounding pad logic can build the tri-state bus. The controller drives data only inside the write strobe. After any read it waits out the RAM's output turn-off before the next access can begin.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst_n` is low, `ram_ce_n`, `ram_oe_n` and `ram_we_n` are high, `ram_dq_oe`, `busy` and `rd_valid` are low.
- R2: A request (`req` high while `busy` is low) is accepted at a rising edge. `busy` is high from the next cycle until the access, including its recovery or turnaround, has finished. `req` while `busy` is high is ignored and causes no RAM access.
- R3: A read holds `ram_ce_n` and `ram_oe_n` low and `ram_we_n` high for ACC+1 cycles, where ACC = ceil(T_AA_NS/CLK_NS), minimum 1. `ram_addr` equals the accepted address and stays stable while `ram_ce_n` is low.
- R4: Read data is sampled from `ram_dq_i` at the edge that ends the read. `rd_data` then holds it and `rd_valid` is high for exactly one cycle.
- R5: After every read, the controller spends TA = ceil(T_OHZ_NS/CLK_NS) cycles (minimum 1) with all strobes high before `busy` falls. The controller never drives data while the RAM's drivers may still be on.
- R6: A write keeps `ram_oe_n` high. It spends SU = ceil(T_SA_NS/CLK_NS) cycles (minimum 1) with `ram_ce_n` low and `ram_we_n` high. It then spends PW = ceil(max(T_PWE_NS,T_SD_NS)/CLK_NS) cycles (minimum 1) with `ram_we_n` low, `ram_dq_oe` high and `ram_dq_o` equal to the accepted write data. It ends with one cycle with `ram_we_n` high, `ram_ce_n` low and `ram_dq_oe` low.
- R7: `ram_dq_oe` is high only when `ram_ce_n` and `ram_we_n` are low and `ram_oe_n` is high.
- R8: Every write ends by `ram_we_n` rising while `ram_ce_n` is still low.
- R9: A word written to an address is returned by any later read of that address until that address is written again.
- R10: Whenever `busy` is low, all three strobes are high and `ram_dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Word address |
| wr_data | input | 4 | Write data |
| rd_data | output | 4 | Last read word |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is new |
| busy | output | 1 | Access in progress |
| ram_ce_n | output | 1 | RAM select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_addr | output | 20 | RAM address |
| ram_dq_o | output | 4 | Data toward RAM |
| ram_dq_oe | output | 1 | Enable for the controller's data drivers |
| ram_dq_i | input | 4 | Data from the RAM pins |

## Verification
The assertions assume that reset is applied for at least one edge and that the timing parameters give phase counts that fit the counter. They also assume the requester obeys the busy handshake only in the sense that stray strobes are harmless. The bench raises `req` only at negative edges. It deliberately holds a conflicting write request high during a busy period to show that the request is ignored. A behavioural RAM on the bench returns corrupted data until the access time has elapsed. It commits writes only at the edge that ends the overlap, and it reports bus contention, short write strobes and short data setup, so every run stays inside the RAM's legal timing.

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int CLK_NS   = 10,
  parameter int T_AA_NS  = 10,
  parameter int T_OHZ_NS = 5,
  parameter int T_PWE_NS = 7,
  parameter int T_SD_NS  = 5,
  parameter int T_SA_NS  = 0,
  parameter int AW       = 20,
  parameter int DW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          busy,
  output logic          ram_ce_n,
  output logic          ram_oe_n,
  output logic          ram_we_n,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_i
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int ACC_C = cyc(T_AA_NS);
  localparam int TA_C  = cyc(T_OHZ_NS);
  localparam int SU_C  = cyc(T_SA_NS);
  localparam int PW_C  = cyc((T_PWE_NS > T_SD_NS) ? T_PWE_NS : T_SD_NS);
  localparam int MAXC  = (ACC_C > TA_C ? ACC_C : TA_C) > (SU_C > PW_C ? SU_C : PW_C)
                         ? (ACC_C > TA_C ? ACC_C : TA_C) : (SU_C > PW_C ? SU_C : PW_C);
  localparam int CW    = $clog2(MAXC + 1);

  if (CLK_NS < 1 || T_AA_NS < 0 || T_OHZ_NS < 0 || T_PWE_NS < 0 || T_SD_NS < 0 || T_SA_NS < 0)
  begin : g_bad_timing
    $error("asram_ctrl: illegal timing parameters");
  end

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ACC, S_RD_CAP, S_WR_SU, S_WR_PUL, S_WR_REC, S_TURN
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      wdat_q   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          addr_q <= addr;
          wdat_q <= wr_data;
          if (wr) begin st <= S_WR_SU;  cnt <= CW'(SU_C - 1);  end
          else    begin st <= S_RD_ACC; cnt <= CW'(ACC_C - 1); end
        end
        S_RD_ACC: if (cnt == '0) st <= S_RD_CAP; else cnt <= cnt - 1'b1;
        S_RD_CAP: begin
          rd_data  <= ram_dq_i;
          rd_valid <= 1'b1;
          st       <= S_TURN;
          cnt      <= CW'(TA_C - 1);
        end
        S_TURN:   if (cnt == '0) st <= S_IDLE; else cnt <= cnt - 1'b1;
        S_WR_SU:  if (cnt == '0) begin st <= S_WR_PUL; cnt <= CW'(PW_C - 1); end
                  else cnt <= cnt - 1'b1;
        S_WR_PUL: if (cnt == '0) st <= S_WR_REC; else cnt <= cnt - 1'b1;
        S_WR_REC: st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign ram_ce_n  = (st == S_IDLE) || (st == S_TURN);
  assign ram_oe_n  = !((st == S_RD_ACC) || (st == S_RD_CAP));
  assign ram_we_n  = (st != S_WR_PUL);
  assign ram_dq_oe = (st == S_WR_PUL);
  assign ram_dq_o  = wdat_q;
  assign ram_addr  = addr_q;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          rd_valid,
  input logic          ram_ce_n,
  input logic          ram_oe_n,
  input logic          ram_we_n,
  input logic          ram_dq_oe,
  input logic [AW-1:0] ram_addr
);

  p_drive_in_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (!ram_ce_n && !ram_we_n && ram_oe_n));

  p_we_ends_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> !ram_ce_n);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce_n && !$past(ram_ce_n)) |-> $stable(ram_addr));

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ram_ce_n && ram_oe_n && ram_we_n && !ram_dq_oe));

  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |=> (ram_we_n && !ram_dq_oe));

endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_valid(rd_valid),
  .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
  .ram_dq_oe(ram_dq_oe), .ram_addr(ram_addr)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb_top;
  localparam int CLK_PERIOD = 4;
  localparam int T_AA = 10, T_OHZ = 5, T_PWE = 7, T_SD = 5;
  localparam int ACC = (T_AA + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int TA  = (T_OHZ + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int SU  = 1;
  localparam int PW  = (T_PWE + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [19:0] addr = '0;
  logic [3:0]  wr_data = '0;
  logic [3:0]  rd_data, ram_dq_o, ram_dq_i;
  logic rd_valid, busy, ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe;
  logic [19:0] ram_addr;

  int errs = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_ctrl #(.CLK_NS(CLK_PERIOD), .T_AA_NS(T_AA), .T_OHZ_NS(T_OHZ),
               .T_PWE_NS(T_PWE), .T_SD_NS(T_SD), .T_SA_NS(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .ram_ce_n(ram_ce_n),
    .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .ram_addr(ram_addr),
    .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i));

  // behavioural RAM
  logic [3:0] ram [int];
  logic [3:0] exp_mem [int];
  int rd_cnt = 0, off_cnt = 100, we_cnt = 0, sd_cnt = 0;
  logic prev_wr = 0, prev_oe = 0;
  logic [3:0] prev_d = '0;
  logic [19:0] prev_a = '0;

  function automatic logic [3:0] ram_rd(input logic [19:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : 4'h0;
  endfunction

  wire ram_drv = !ram_ce_n && !ram_oe_n && ram_we_n;
  assign ram_dq_i = ram_drv ? (((rd_cnt - 1) * CLK_PERIOD >= T_AA) ? ram_rd(ram_addr)
                                                                   : ~ram_rd(ram_addr))
                  : (ram_dq_oe ? ram_dq_o : 4'hx);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic cur_wr;
    cur_wr = !ram_ce_n && !ram_we_n;
    chk(!(ram_drv && ram_dq_oe), "R7 contention", 1, 0);
    if (ram_dq_oe && !prev_oe)
      chk((off_cnt - 1) * CLK_PERIOD >= T_OHZ, "R5 turn-off time", off_cnt, 0);
    if (prev_wr && !cur_wr) begin
      chk(!ram_ce_n, "R8 write ended by WE", ram_ce_n, 0);
      chk(we_cnt * CLK_PERIOD >= T_PWE, "R6 strobe width", we_cnt, PW);
      chk(sd_cnt * CLK_PERIOD >= T_SD, "R6 data setup", sd_cnt, PW);
      if (prev_oe) ram[int'(prev_a)] = prev_d;
    end
    rd_cnt  = ram_drv ? rd_cnt + 1 : 0;
    off_cnt = ram_drv ? 0 : (off_cnt < 100 ? off_cnt + 1 : off_cnt);
    we_cnt  = cur_wr ? we_cnt + 1 : 0;
    sd_cnt  = (cur_wr && ram_dq_oe && (!prev_oe || ram_dq_o == prev_d)) ? sd_cnt + 1 : 0;
    prev_wr = cur_wr; prev_oe = ram_dq_oe; prev_d = ram_dq_o; prev_a = ram_addr;
  end

  function automatic logic [3:0] exp_rd(input logic [19:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 4'h0;
  endfunction

  // cycle-by-cycle reference of one access; entered and left at a negedge
  task automatic op(input bit w, input logic [19:0] a, input logic [3:0] d, input bit stray);
    int len;
    logic [3:0] e;
    len = w ? SU + PW + 1 : ACC + 1 + TA;
    req = 1; wr = w; addr = a; wr_data = d;
    e = exp_rd(a);
    @(posedge clk);
    if (w) exp_mem[int'(a)] = d;
    for (int n = 1; n <= len + 1; n++) begin
      bit x_ce, x_oe, x_we, x_dq, x_bz, x_rv;
      @(negedge clk);
      if (stray && n < 3) begin req = 1; wr = 1; addr = a; wr_data = ~d; end
      else req = 0;
      x_bz = (n <= len);
      if (w) begin
        x_ce = (n <= len); x_oe = 0;
        x_we = (n > SU && n <= SU + PW); x_dq = x_we; x_rv = 0;
      end else begin
        x_ce = (n <= ACC + 1); x_oe = x_ce; x_we = 0; x_dq = 0; x_rv = (n == ACC + 2);
      end
      chk(busy == x_bz, "R2 busy", busy, x_bz);
      chk(ram_ce_n == !x_ce, w ? "R6 ce" : "R3 ce", ram_ce_n, !x_ce);
      chk(ram_oe_n == !x_oe, w ? "R6 oe" : "R5 oe", ram_oe_n, !x_oe);
      chk(ram_we_n == !x_we, "R6 we", ram_we_n, !x_we);
      chk(ram_dq_oe == x_dq, "R7 dq_oe", ram_dq_oe, x_dq);
      chk(rd_valid == x_rv, "R4 rd_valid", rd_valid, x_rv);
      if (x_ce) chk(ram_addr == a, "R3 address", ram_addr, a);
      if (x_dq) chk(ram_dq_o == d, "R6 write data", ram_dq_o, d);
      if (x_rv) chk(rd_data == e, "R9 read data", rd_data, e);
      if (!x_bz) chk(ram_ce_n && ram_oe_n && ram_we_n, "R10 idle strobes", 0, 1);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ram_ce_n && ram_oe_n && ram_we_n, "R1 strobes in reset", 0, 1);
    chk(!ram_dq_oe && !busy && !rd_valid, "R1 outputs in reset", 1, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy, "R1 idle after reset", busy, 0);
    op(0, 20'h00000, 4'h0, 0);           // R9 unwritten reads zero
    op(1, 20'h00000, 4'h5, 0);
    op(1, 20'hFFFFF, 4'hA, 0);
    op(0, 20'hFFFFF, 4'h0, 0);
    op(0, 20'h00000, 4'h0, 0);
    op(1, 20'h12345, 4'hC, 0);           // R5 read directly followed by write
    op(0, 20'h12345, 4'h0, 1);           // R2 stray write during busy ignored
    op(0, 20'h12345, 4'h0, 0);
    op(1, 20'h12345, 4'h3, 0);           // R9 overwrite
    op(0, 20'h12345, 4'h0, 0);
    for (int i = 0; i < 8; i++) op(1, 20'(i * 20'h1F0F1), 4'(i * 3 + 1), 0);
    for (int i = 7; i >= 0; i--) op(0, 20'(i * 20'h1F0F1), 4'h0, 0);
    done = 1;
    summary();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end
endmodule